// File: doc/BRIEF.md
# Cascaded Two-Output Interrupt Controller

This block gathers level-sensitive interrupt requests into two CPU request lines. Two local banks of eight sources each have their own enable mask. A third bank of eight shared sources is gated by two independent masks. Each gated view collapses into one fixed bit of a local bank, so a shared source can reach either CPU line, both, or neither. Two timer event pulses are held in sticky flags, which also appear as fixed bits of the second local bank. Software clears those flags through a write-one-to-clear register.

Software uses a 32-bit word bus with byte addresses on a 4-byte stride. It sets mask bits to enable sources. It reads the status registers to find which sources are raised. When handling a timer event, it writes the clear register.

Logical source numbering: local bank 0 is sources 0–7, local bank 1 is sources 8–15, the shared bank seen through mask A is 16–23, and seen through mask B is 24–31.

Top module: `cirq_top`

## Requirements
- R1: After a synchronous reset, all four mask registers read zero, both timer flags are clear and both `cpu_irq` bits are low.
- R2: `cpu_irq[0]` is the OR of (bank-0 status AND bank-0 mask) and `cpu_irq[1]` the same for bank 1. Both are levels that follow inputs and masks in the same cycle and drop when the cause is removed or masked.
- R3: Mask registers are at byte offsets 0x04 (bank 0), 0x0C (bank 1), 0x14 (shared mask A) and 0x18 (shared mask B). A write stores `bus_wdata[7:0]` on the clock edge. A read returns the stored value in bits 7:0 and zero in bits 31:8.
- R4: Status registers read at 0x00 (bank 0), 0x08 (bank 1) and 0x10 (shared bank), with bits 31:8 zero. Writes to them change nothing.
- R5: Bank-0 status bit 7 is the OR of (shared status AND mask A). Bank-1 status bit 3 is the OR of (shared status AND mask B). Both masks gate the same shared status, and the raw bank inputs at those two bit positions are ignored.
- R6: A one-cycle pulse on `tmr_evt[i]` sets a sticky flag that stays set until cleared. Flag 0 is bank-1 status bit 0 and flag 1 is bit 1. The raw bank-1 inputs at bits 0 and 1 are ignored.
- R7: A write to offset 0x1C clears flag i where `bus_wdata[i]` is 1, so 0x03 clears both. If a clear and a new event for the same flag arrive in the same cycle, the flag stays set.
- R8: Reads of offset 0x1C and of 0x20–0x3C return zero. Writes to 0x20–0x3C change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wr | input | 1 | Write strobe, captured on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| l0_req | input | 8 | Bank-0 raw requests (bit 7 unused) |
| l1_req | input | 8 | Bank-1 raw requests (bits 0, 1, 3 unused) |
| map_req | input | 8 | Shared-bank raw requests |
| tmr_evt | input | 2 | Timer event pulses |
| cpu_irq | output | 2 | CPU request levels |

## Verification
The assertions check on every cycle that:
- masks load only on their own write and hold otherwise;
- timer flags are sticky, and an event wins over a clear in the same cycle;
- an enabled shared source always reaches `cpu_irq[0]` through its cascade;
- `cpu_irq[1]` is never raised with an all-zero bank-1 mask.

Only the directed scenarios can show the remaining behaviour:
- the address decode and the zero upper read bits;
- that writes to status and unmapped offsets are ignored;
- that the raw inputs at the cascade and timer bit positions are overridden;
- that a request drops out in the same cycle it is removed.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
    localparam int BANK_W     = 8;
    localparam int DATA_W     = 32;
    localparam int WORD_IDX_W = 4;
    localparam int ADDR_W     = WORD_IDX_W + 2;
    localparam int NUM_TMR    = 2;
    localparam int NUM_VIEW   = 2;
    localparam int CAS0_BIT   = 7;
    localparam int CAS1_BIT   = 3;
    localparam int TMR_BIT0   = 0;

    typedef enum logic [WORD_IDX_W-1:0] {
        W_L0_STAT  = 4'd0,
        W_L0_MASK  = 4'd1,
        W_L1_STAT  = 4'd2,
        W_L1_MASK  = 4'd3,
        W_MAP_STAT = 4'd4,
        W_MAP_MSKA = 4'd5,
        W_MAP_MSKB = 4'd6,
        W_TMR_CLR  = 4'd7
    } word_e;

    function automatic logic [DATA_W-1:0] widen(input logic [BANK_W-1:0] v);
        return {{(DATA_W-BANK_W){1'b0}}, v};
    endfunction
endpackage

// File: rtl/cirq_mask_bank.sv
module cirq_mask_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic [W-1:0] pend,
    output logic         any
);
    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)        mask_q <= '0;
        else if (wr_en) mask_q <= wr_data;
    end

    assign mask = mask_q;
    assign pend = status & mask_q;
    assign any  = |pend;

    a_r1_mask_cleared: assert property (@(posedge clk) rst |=> (mask_q == '0));
    a_r3_mask_holds:   assert property (@(posedge clk) disable iff (rst)
                                        !wr_en |=> $stable(mask_q));
    a_r3_mask_loads:   assert property (@(posedge clk) disable iff (rst)
                                        wr_en |=> (mask_q == $past(wr_data)));
endmodule

// File: rtl/cirq_evt_latch.sv
module cirq_evt_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~clr_i) | set_i;
    end

    assign flag_o = flag_q;

    a_r1_flags_cleared: assert property (@(posedge clk) rst |=> (flag_q == '0));

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r6_sticky:    assert property (@(posedge clk) disable iff (rst)
                                         (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
        a_r7_set_wins:  assert property (@(posedge clk) disable iff (rst)
                                         set_i[i] |=> flag_q[i]);
        a_r7_clear_hit: assert property (@(posedge clk) disable iff (rst)
                                         (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
    end
endmodule

// File: rtl/cirq_top.sv
module cirq_top
    import cirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        l0_req,
    input  logic [7:0]        l1_req,
    input  logic [7:0]        map_req,
    input  logic [1:0]        tmr_evt,
    output logic [1:0]        cpu_irq
);
    logic [WORD_IDX_W-1:0] word;
    logic [NUM_TMR-1:0]    tmr_flag;
    logic [NUM_TMR-1:0]    tmr_clr;

    logic [BANK_W-1:0] view_mask [NUM_VIEW];
    logic [BANK_W-1:0] view_pend [NUM_VIEW];
    logic [NUM_VIEW-1:0] view_any;
    logic [NUM_VIEW-1:0] view_wr;

    logic [BANK_W-1:0] loc_stat [NUM_VIEW];
    logic [BANK_W-1:0] loc_mask [NUM_VIEW];
    logic [BANK_W-1:0] loc_pend [NUM_VIEW];
    logic [NUM_VIEW-1:0] loc_any;
    logic [NUM_VIEW-1:0] loc_wr;

    assign word = bus_addr[ADDR_W-1:2];

    assign loc_wr[0]  = bus_wr && (word == W_L0_MASK);
    assign loc_wr[1]  = bus_wr && (word == W_L1_MASK);
    assign view_wr[0] = bus_wr && (word == W_MAP_MSKA);
    assign view_wr[1] = bus_wr && (word == W_MAP_MSKB);
    assign tmr_clr    = (bus_wr && (word == W_TMR_CLR)) ? bus_wdata[NUM_TMR-1:0] : '0;

    // Shared bank, seen through two independent masks
    for (genvar v = 0; v < NUM_VIEW; v++) begin : g_view
        cirq_mask_bank #(.W(BANK_W)) u_view (
            .clk(clk), .rst(rst), .wr_en(view_wr[v]),
            .wr_data(bus_wdata[BANK_W-1:0]), .status(map_req),
            .mask(view_mask[v]), .pend(view_pend[v]), .any(view_any[v])
        );
    end

    cirq_evt_latch #(.N(NUM_TMR)) u_tmr (
        .clk(clk), .rst(rst), .set_i(tmr_evt), .clr_i(tmr_clr), .flag_o(tmr_flag)
    );

    // Local status: raw inputs with cascade and timer bits overridden
    always_comb begin
        loc_stat[0]           = l0_req;
        loc_stat[0][CAS0_BIT] = view_any[0];
        loc_stat[1]           = l1_req;
        loc_stat[1][CAS1_BIT] = view_any[1];
        loc_stat[1][TMR_BIT0 +: NUM_TMR] = tmr_flag;
    end

    for (genvar b = 0; b < NUM_VIEW; b++) begin : g_loc
        cirq_mask_bank #(.W(BANK_W)) u_loc (
            .clk(clk), .rst(rst), .wr_en(loc_wr[b]),
            .wr_data(bus_wdata[BANK_W-1:0]), .status(loc_stat[b]),
            .mask(loc_mask[b]), .pend(loc_pend[b]), .any(loc_any[b])
        );
    end

    assign cpu_irq = loc_any;

    always_comb begin
        case (word)
            W_L0_STAT:  bus_rdata = widen(loc_stat[0]);
            W_L0_MASK:  bus_rdata = widen(loc_mask[0]);
            W_L1_STAT:  bus_rdata = widen(loc_stat[1]);
            W_L1_MASK:  bus_rdata = widen(loc_mask[1]);
            W_MAP_STAT: bus_rdata = widen(map_req);
            W_MAP_MSKA: bus_rdata = widen(view_mask[0]);
            W_MAP_MSKB: bus_rdata = widen(view_mask[1]);
            default:    bus_rdata = '0;
        endcase
    end

    a_r5_cascade_a: assert property (@(posedge clk) disable iff (rst)
        ((|(map_req & view_mask[0])) && loc_mask[0][CAS0_BIT]) |-> cpu_irq[0]);
    a_r5_cascade_b: assert property (@(posedge clk) disable iff (rst)
        ((|(map_req & view_mask[1])) && loc_mask[1][CAS1_BIT]) |-> cpu_irq[1]);
    a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        cpu_irq[1] |-> (loc_mask[1] != '0));
endmodule

// File: tb/tb_cirq_top.sv
module tb_cirq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  l0_req = '0, l1_req = '0, map_req = '0;
    logic [1:0]  tmr_evt = '0;
    logic [1:0]  cpu_irq;

    int n_chk = 0;
    int n_bad = 0;

    cirq_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .l0_req(l0_req),
        .l1_req(l1_req), .map_req(map_req), .tmr_evt(tmr_evt), .cpu_irq(cpu_irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h want 0x%08h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string rq, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(rq, bus_rdata, exp);
    endtask

    task automatic irq_chk(input string rq, input logic [1:0] exp);
        #1;
        chk(rq, {30'd0, cpu_irq}, {30'd0, exp});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd_chk("R1 l0 mask", 6'h04, 32'h0);
        rd_chk("R1 l1 mask", 6'h0C, 32'h0);
        rd_chk("R1 mask A",  6'h14, 32'h0);
        rd_chk("R1 mask B",  6'h18, 32'h0);
        rd_chk("R1 timer flags", 6'h08, 32'h0);
        irq_chk("R1 irq low", 2'b00);
    endtask

    task automatic t_mask_rw();
        wr(6'h04, 32'hFFFF_FFA5);
        wr(6'h0C, 32'h1234_565A);
        wr(6'h14, 32'h0000_0133);
        wr(6'h18, 32'hABCD_EFCC);
        rd_chk("R3 l0 mask", 6'h04, 32'hA5);
        rd_chk("R3 l1 mask", 6'h0C, 32'h5A);
        rd_chk("R3 mask A",  6'h14, 32'h33);
        rd_chk("R3 mask B",  6'h18, 32'hCC);
        wr(6'h04, 0); wr(6'h0C, 0); wr(6'h14, 0); wr(6'h18, 0);
    endtask

    task automatic t_status();
        l0_req = 8'h3C;
        rd_chk("R4 l0 status", 6'h00, 32'h3C);
        l0_req = 8'hFF;
        rd_chk("R5 raw bit7 ignored", 6'h00, 32'h7F);
        wr(6'h00, 32'h0000_0000);
        rd_chk("R4 status write ignored", 6'h00, 32'h7F);
        map_req = 8'h81;
        rd_chk("R4 map status", 6'h10, 32'h81);
        wr(6'h10, 32'h0);
        rd_chk("R4 map status write ignored", 6'h10, 32'h81);
        l1_req = 8'hFF;
        rd_chk("R6 l1 raw bits 0,1,3 ignored", 6'h08, 32'hF4);
        l0_req = 0; l1_req = 0; map_req = 0;
    endtask

    task automatic t_local();
        l0_req = 8'h01;
        irq_chk("R2 masked off", 2'b00);
        wr(6'h04, 32'h01);
        irq_chk("R2 enabled raises", 2'b01);
        l0_req = 8'h00;
        irq_chk("R2 removal drops same cycle", 2'b00);
        l0_req = 8'h01;
        wr(6'h04, 32'h02);
        irq_chk("R2 masking drops", 2'b00);
        l1_req = 8'h10;
        wr(6'h0C, 32'h10);
        irq_chk("R2 bank1 only", 2'b10);
        l0_req = 0; l1_req = 0;
        wr(6'h04, 0); wr(6'h0C, 0);
    endtask

    task automatic t_cascade();
        wr(6'h04, 32'h80);
        wr(6'h0C, 32'h08);
        map_req = 8'h04;
        irq_chk("R5 no view mask", 2'b00);
        wr(6'h14, 32'h04);
        irq_chk("R5 view A to irq0", 2'b01);
        rd_chk("R5 l0 bit7 set", 6'h00, 32'h80);
        wr(6'h18, 32'h04);
        irq_chk("R5 both views", 2'b11);
        rd_chk("R5 l1 bit3 set", 6'h08, 32'h08);
        wr(6'h14, 32'h00);
        irq_chk("R5 view B only", 2'b10);
        map_req = 8'h00;
        l0_req = 8'h80;
        irq_chk("R5 raw bit7 cannot raise", 2'b00);
        l0_req = 0;
        wr(6'h04, 0); wr(6'h0C, 0); wr(6'h18, 0);
    endtask

    task automatic t_timer();
        wr(6'h0C, 32'h03);
        @(negedge clk); tmr_evt = 2'b01;
        @(negedge clk); tmr_evt = 2'b00;
        repeat (3) @(negedge clk);
        rd_chk("R6 flag0 sticky", 6'h08, 32'h01);
        irq_chk("R6 flag0 irq", 2'b10);
        tmr_evt = 2'b10;
        @(negedge clk); tmr_evt = 2'b00;
        rd_chk("R6 flag1 set", 6'h08, 32'h03);
        wr(6'h1C, 32'h01);
        rd_chk("R7 clear flag0 only", 6'h08, 32'h02);
        @(negedge clk);
        bus_addr = 6'h1C; bus_wdata = 32'h02; bus_wr = 1'b1; tmr_evt = 2'b10;
        @(negedge clk);
        bus_wr = 1'b0; tmr_evt = 2'b00;
        rd_chk("R7 event wins over clear", 6'h08, 32'h02);
        wr(6'h1C, 32'h03);
        rd_chk("R7 0x03 clears both", 6'h08, 32'h00);
        irq_chk("R7 irq drops after clear", 2'b00);
        l1_req = 8'h03;
        irq_chk("R6 raw bits 0,1 ignored", 2'b00);
        l1_req = 0;
        wr(6'h0C, 0);
    endtask

    task automatic t_unmapped();
        wr(6'h04, 32'h11); wr(6'h0C, 32'h22); wr(6'h14, 32'h44); wr(6'h18, 32'h88);
        rd_chk("R8 read clear reg zero", 6'h1C, 32'h0);
        rd_chk("R8 read 0x20 zero", 6'h20, 32'h0);
        rd_chk("R8 read 0x3C zero", 6'h3C, 32'h0);
        wr(6'h24, 32'hFF); wr(6'h34, 32'hFF); wr(6'h3C, 32'hFF);
        rd_chk("R8 l0 mask untouched", 6'h04, 32'h11);
        rd_chk("R8 l1 mask untouched", 6'h0C, 32'h22);
        rd_chk("R8 mask A untouched", 6'h14, 32'h44);
        rd_chk("R8 mask B untouched", 6'h18, 32'h88);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_mask_rw();
        t_status();
        t_local();
        t_cascade();
        t_timer();
        t_unmapped();
        t_reset();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got 0x%08h want 0x%08h", 32'h1, 32'h0);
        finish_run();
    end
endmodule